// File: doc/BRIEF.md
# Alternate Boot Watchdog Controller

This block supervises fail-over booting for a flash controller with two chip selects. When a strap input arms it, a watchdog counter starts at every system reset while the processor fetches its first code from the flash on chip select 0. Firmware that comes up correctly clears the enable bit in the block's control/status word, which stops the count. If the count runs out first, the block raises a reset request for a fixed number of cycles and flips the mapping of the two chip selects, so the following boot fetches from the other flash.

The swap state doubles as a sticky boot-source status bit. It survives the system reset that the block itself requests, and only the power-on reset input clears it. A second expiry while running from the alternate flash flips the mapping back to the primary one. Two further strap inputs describe the boot arrangement (single-boot flag, one-chip versus two-chip layout). They are captured at each system reset and reported as read-only status bits.

Software reaches the block through a simple register bus. It has a byte address, a write strobe and 32-bit data, and holds one control/status word at byte offset 0x64. Outside this block, the reset request is normally fed back into the system reset.

Top module: `altboot_wdt`

## Requirements
- R1: Power-on reset (`por_i` high, synchronous) clears the chip-select swap and the reset request. After it, the word's bit 0 equals `strap_arm_i` and bit 4 reads 0.
- R2: When armed and left alone, the reset request rises exactly TIMEOUT clock edges after the last edge that sampled reset. `cs_swap_o` toggles at that same edge.
- R3: The reset request stays high for exactly RST_LEN consecutive cycles per expiry.
- R4: Writing 0 to bit 0 at offset 0x64 before expiry stops the count. No reset request follows and the swap keeps its value.
- R5: The swap state and the boot-source bit keep their value through a system reset, including the one the block requests. They change only on expiry or on power-on reset.
- R6: An expiry while the swap is already set clears it again, so the mapping returns to the primary flash and bit 4 returns to 0.
- R7: Word layout at offset 0x64: bit 0 is the watchdog enable. Bit 4 is the boot source (0 primary, 1 alternate) and always equals `cs_swap_o`. Bit 5 is the single-boot strap and bit 6 is the one-chip strap (0 two chips, 1 one chip); both are captured at system reset only. All other bits read 0.
- R8: Only bit 0 is writable. Written values of bits 31:1 are discarded. Writes at any other offset change nothing, and reads at any other offset return 0.
- R9: Writing 1 to bit 0 while it is 0 restarts the count from the full TIMEOUT. Writing 1 while it is already 1 leaves the running count untouched.
- R10: With `strap_arm_i` low at system reset, bit 0 reads 0 and no reset request occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high; clears all state |
| sys_rst_i | input | 1 | System reset, synchronous, active high; reloads counter, enable and strap status |
| strap_arm_i | input | 1 | Arms the watchdog at system reset |
| strap_single_boot_i | input | 1 | Single-boot flag, captured at system reset |
| strap_one_chip_i | input | 1 | Boot layout strap (0 two chips, 1 one chip), captured at system reset |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| rst_req_o | output | 1 | System reset request, RST_LEN cycles per expiry |
| cs_swap_o | output | 1 | 1 when chip selects 0 and 1 are swapped |

## Verification
Every cycle, the assertions check several properties: each rise of the reset request coincides with a toggle of the swap, the swap never moves without such a rise, and every pulse lasts exactly RST_LEN cycles. They also check that no expiry follows a cycle with the enable off, that bit 4 of the word tracks `cs_swap_o`, and that power-on reset clears both outputs. Other properties depend on a whole history of writes and resets, so only the bench's scenarios can show them. These are the exact expiry cycle after reset or after a re-enable, a redundant enable write that does not restart the count, a masked write or stray-offset write that leaves the enable off, strap capture only at reset, and the swap surviving the block's own reset but not power-on reset.

// File: rtl/altboot_pkg.sv
package altboot_pkg;

    // Field positions inside the control/status word
    localparam int unsigned BIT_EN       = 0;
    localparam int unsigned BIT_SRC      = 4;
    localparam int unsigned BIT_SINGLE   = 5;
    localparam int unsigned BIT_ONE_CHIP = 6;

    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] WRITE_MASK = WORD_W'(1) << BIT_EN;

    typedef struct packed {
        logic one_chip;
        logic single_boot;
        logic boot_alt;
        logic wdt_en;
    } abr_status_t;

    typedef enum logic [1:0] {
        PH_HOLD,
        PH_COUNT,
        PH_LAST,
        PH_SPENT
    } wdt_phase_e;

    function automatic logic [WORD_W-1:0] pack_status(input abr_status_t s);
        logic [WORD_W-1:0] w;
        w               = '0;
        w[BIT_EN]       = s.wdt_en;
        w[BIT_SRC]      = s.boot_alt;
        w[BIT_SINGLE]   = s.single_boot;
        w[BIT_ONE_CHIP] = s.one_chip;
        return w;
    endfunction

endpackage

// File: rtl/altboot_csr.sv
module altboot_csr
    import altboot_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CSR_OFFSET = 32'h64
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              strap_arm_i,
    input  logic              strap_single_boot_i,
    input  logic              strap_one_chip_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    input  logic              boot_alt_i,
    output logic              wdt_en_o,
    output logic              restart_o,
    output logic [WORD_W-1:0] bus_rdata_o
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CSR_OFFSET);

    logic        hit;
    logic        wr_hit;
    logic        wr_en_val;
    logic        en_q;
    logic        single_q;
    logic        one_chip_q;
    abr_status_t status;

    assign hit       = bus_en_i && (bus_addr_i == HIT_ADDR);
    assign wr_hit    = hit && bus_we_i;
    assign wr_en_val = (bus_wdata_i & WRITE_MASK) != '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q       <= strap_arm_i;
            single_q   <= strap_single_boot_i;
            one_chip_q <= strap_one_chip_i;
        end else if (wr_hit) begin
            en_q <= wr_en_val;
        end
    end

    // Only a 0 -> 1 transition reloads the counter
    assign restart_o = wr_hit && wr_en_val && !en_q && !rst_i;
    assign wdt_en_o  = en_q;

    always_comb begin
        status.wdt_en      = en_q;
        status.boot_alt    = boot_alt_i;
        status.single_boot = single_q;
        status.one_chip    = one_chip_q;
    end

    assign bus_rdata_o = (hit && !bus_we_i) ? pack_status(status) : '0;

endmodule

// File: rtl/altboot_counter.sv
module altboot_counter
    import altboot_pkg::*;
#(
    parameter int unsigned TIMEOUT = 1000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic restart_i,
    output logic expire_o
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TIMEOUT);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    wdt_phase_e       phase;

    always_comb begin
        if (!run_i)               phase = PH_HOLD;
        else if (cnt_q == '0)     phase = PH_SPENT;
        else if (cnt_q == CNT_ONE) phase = PH_LAST;
        else                      phase = PH_COUNT;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            cnt_q <= CNT_FULL;
        end else begin
            unique case (phase)
                PH_COUNT, PH_LAST: cnt_q <= cnt_q - CNT_ONE;
                default:           cnt_q <= cnt_q;
            endcase
        end
    end

    // Saturates at zero, so expiry fires once per load
    assign expire_o = (phase == PH_LAST) && !rst_i && !restart_i;

endmodule

// File: rtl/altboot_pulse.sv
module altboot_pulse #(
    parameter int unsigned RST_LEN = 4
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic fire_i,
    output logic req_o
);

    localparam int unsigned PLS_W = $clog2(RST_LEN + 1);
    localparam logic [PLS_W-1:0] PLS_FULL = PLS_W'(RST_LEN);

    logic [PLS_W-1:0] left_q;

    // Deliberately not cleared by the system reset it drives
    always_ff @(posedge clk_i) begin
        if (por_i)              left_q <= '0;
        else if (fire_i)        left_q <= PLS_FULL;
        else if (left_q != '0)  left_q <= left_q - PLS_W'(1);
    end

    assign req_o = (left_q != '0);

endmodule

// File: rtl/altboot_map.sv
module altboot_map (
    input  logic clk_i,
    input  logic por_i,
    input  logic toggle_i,
    output logic swap_o
);

    logic swap_q;

    always_ff @(posedge clk_i) begin
        if (por_i)         swap_q <= 1'b0;
        else if (toggle_i) swap_q <= !swap_q;
    end

    assign swap_o = swap_q;

endmodule

// File: rtl/altboot_wdt.sv
module altboot_wdt
    import altboot_pkg::*;
#(
    parameter int unsigned TIMEOUT    = 1000,
    parameter int unsigned RST_LEN    = 4,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CSR_OFFSET = 32'h64
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              sys_rst_i,
    input  logic              strap_arm_i,
    input  logic              strap_single_boot_i,
    input  logic              strap_one_chip_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              rst_req_o,
    output logic              cs_swap_o
);

    logic any_rst;
    logic wdt_en;
    logic restart;
    logic expire;
    logic swap;

    assign any_rst = por_i || sys_rst_i;

    altboot_csr #(
        .ADDR_W     (ADDR_W),
        .CSR_OFFSET (CSR_OFFSET)
    ) u_csr (
        .clk_i               (clk_i),
        .rst_i               (any_rst),
        .strap_arm_i         (strap_arm_i),
        .strap_single_boot_i (strap_single_boot_i),
        .strap_one_chip_i    (strap_one_chip_i),
        .bus_en_i            (bus_en_i),
        .bus_we_i            (bus_we_i),
        .bus_addr_i          (bus_addr_i),
        .bus_wdata_i         (bus_wdata_i),
        .boot_alt_i          (swap),
        .wdt_en_o            (wdt_en),
        .restart_o           (restart),
        .bus_rdata_o         (bus_rdata_o)
    );

    altboot_counter #(
        .TIMEOUT (TIMEOUT)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (any_rst),
        .run_i     (wdt_en),
        .restart_i (restart),
        .expire_o  (expire)
    );

    altboot_pulse #(
        .RST_LEN (RST_LEN)
    ) u_pulse (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .fire_i (expire),
        .req_o  (rst_req_o)
    );

    altboot_map u_map (
        .clk_i    (clk_i),
        .por_i    (por_i),
        .toggle_i (expire),
        .swap_o   (swap)
    );

    assign cs_swap_o = swap;

endmodule

// File: rtl/altboot_wdt_chk.sv
module altboot_wdt_chk #(
    parameter int unsigned RST_LEN    = 4,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CSR_OFFSET = 32'h64
) (
    input logic              clk_i,
    input logic              por_i,
    input logic              wdt_en,
    input logic              bus_en_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_rdata_o,
    input logic              rst_req_o,
    input logic              cs_swap_o
);

    localparam int unsigned HC_W = $clog2(RST_LEN + 2);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CSR_OFFSET);

    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk_i) begin
        if (por_i)          hi_cnt <= '0;
        else if (rst_req_o) hi_cnt <= hi_cnt + HC_W'(1);
        else                hi_cnt <= '0;
    end

    assert_por_clears_R1: assert property (@(posedge clk_i)
        por_i |=> (!cs_swap_o && !rst_req_o));

    assert_expiry_swaps_R2: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(rst_req_o) |-> (cs_swap_o != $past(cs_swap_o)));

    assert_pulse_len_R3: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(rst_req_o) |-> (hi_cnt == HC_W'(RST_LEN)));

    assert_pulse_cap_R3: assert property (@(posedge clk_i) disable iff (por_i)
        hi_cnt <= HC_W'(RST_LEN));

    assert_no_expiry_disabled_R4: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(rst_req_o) |-> $past(wdt_en));

    assert_swap_sticky_R5: assert property (@(posedge clk_i) disable iff (por_i)
        (cs_swap_o != $past(cs_swap_o)) |-> $rose(rst_req_o));

    assert_src_bit_R7: assert property (@(posedge clk_i) disable iff (por_i)
        (bus_en_i && !bus_we_i && bus_addr_i == HIT_ADDR) |-> (bus_rdata_o[4] == cs_swap_o));

    assert_stray_read_R8: assert property (@(posedge clk_i) disable iff (por_i)
        (bus_en_i && !bus_we_i && bus_addr_i != HIT_ADDR) |-> (bus_rdata_o == 32'd0));

endmodule

bind altboot_wdt altboot_wdt_chk #(
    .RST_LEN    (RST_LEN),
    .ADDR_W     (ADDR_W),
    .CSR_OFFSET (CSR_OFFSET)
) u_chk (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .wdt_en      (wdt_en),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .rst_req_o   (rst_req_o),
    .cs_swap_o   (cs_swap_o)
);

// File: tb/sim_altboot_wdt.sv
`timescale 1ns/1ps
module sim_altboot_wdt;

    localparam int unsigned TO  = 40;
    localparam int unsigned RL  = 3;
    localparam int unsigned AW  = 8;
    localparam logic [AW-1:0] CSR  = 8'h64;
    localparam logic [AW-1:0] STRAY = 8'h60;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic tb_rst = 1'b0;
    logic arm = 1'b1, single = 1'b1, one_chip = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic rst_req, cs_swap, sys_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    assign sys_rst = rst_req | tb_rst;

    altboot_wdt #(.TIMEOUT(TO), .RST_LEN(RL), .ADDR_W(AW), .CSR_OFFSET(32'h64)) u0 (
        .clk_i(clk), .por_i(por), .sys_rst_i(sys_rst),
        .strap_arm_i(arm), .strap_single_boot_i(single), .strap_one_chip_i(one_chip),
        .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .rst_req_o(rst_req), .cs_swap_o(cs_swap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] v);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic read_word(input string req, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(CSR, v);
        check(req, v, exp);
    endtask

    // Request must stay low for n-1 falling edges and be high at the n-th
    task automatic wait_fire(input string req, input int n);
        logic low_ok = 1'b1;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (rst_req) low_ok = 1'b0;
        end
        @(negedge clk);
        check({req, " quiet before expiry"}, {31'd0, low_ok}, 32'd1);
        check({req, " expiry edge"}, {31'd0, rst_req}, 32'd1);
    endtask

    task automatic measure_pulse();
        int len = 0;
        while (rst_req) begin
            len++;
            @(negedge clk);
        end
        check("R3 pulse length", len, RL);
    endtask

    task automatic watch_quiet(input string req, input int n);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) hits++;
        end
        check(req, hits, 0);
    endtask

    task automatic sys_reset();
        tb_rst = 1'b1;
        @(negedge clk);
        tb_rst = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 rst_req after por", {31'd0, rst_req}, 32'd0);
        check("R1 swap after por", {31'd0, cs_swap}, 32'd0);
        read_word("R1 R7 word after por", 32'h21);
    endtask

    task automatic t_first_expiry();
        wait_fire("R2 first", TO);
        check("R2 swap set", {31'd0, cs_swap}, 32'd1);
        measure_pulse();
        check("R5 swap kept over own reset", {31'd0, cs_swap}, 32'd1);
        read_word("R7 source bit alternate", 32'h31);
    endtask

    task automatic t_second_expiry();
        wait_fire("R6 second", TO);
        check("R6 swap back", {31'd0, cs_swap}, 32'd0);
        measure_pulse();
        read_word("R6 source bit primary", 32'h21);
    endtask

    task automatic t_rewrite();
        logic low_ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rst_req) low_ok = 1'b0;
        end
        bus_write(CSR, 32'h1);
        check("R9 quiet before redundant write", {31'd0, low_ok}, 32'd1);
        wait_fire("R9 redundant enable keeps count", TO - 21);
        check("R9 swap after expiry", {31'd0, cs_swap}, 32'd1);
        measure_pulse();
    endtask

    task automatic t_sysrst_keep();
        single = 1'b0; one_chip = 1'b1;
        sys_reset();
        check("R5 swap kept over system reset", {31'd0, cs_swap}, 32'd1);
        read_word("R7 straps captured", 32'h51);
        single = 1'b1;
        read_word("R7 strap not sampled outside reset", 32'h51);
    endtask

    task automatic t_clear();
        repeat (10) @(negedge clk);
        bus_write(CSR, 32'h0);
        watch_quiet("R4 no expiry after clear", 3 * TO);
        check("R4 swap unchanged", {31'd0, cs_swap}, 32'd1);
        read_word("R4 enable reads 0", 32'h50);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        bus_write(CSR, 32'hFFFF_FFFE);
        read_word("R8 upper bits masked", 32'h50);
        bus_write(STRAY, 32'hFFFF_FFFF);
        read_word("R8 stray offset write ignored", 32'h50);
        bus_read(STRAY, v);
        check("R8 stray offset reads 0", v, 32'h0);
        watch_quiet("R8 stray write did not enable", 2 * TO);
    endtask

    task automatic t_restart();
        bus_write(CSR, 32'h1);
        wait_fire("R9 restart after clear", TO);
        check("R9 R6 swap toggled back", {31'd0, cs_swap}, 32'd0);
        measure_pulse();
    endtask

    task automatic t_unarmed();
        arm = 1'b0; single = 1'b0; one_chip = 1'b0;
        sys_reset();
        read_word("R10 unarmed word", 32'h00);
        watch_quiet("R10 unarmed no expiry", 2 * TO);
        bus_write(CSR, 32'h1);
        wait_fire("R10 R9 enable by write", TO);
        measure_pulse();
        check("R10 swap set", {31'd0, cs_swap}, 32'd1);
        read_word("R10 not rearmed by own reset", 32'h10);
    endtask

    task automatic t_por_clear();
        por = 1'b1;
        repeat (2) @(negedge clk);
        por = 1'b0;
        check("R1 R5 por clears swap", {31'd0, cs_swap}, 32'd0);
        read_word("R1 word after second por", 32'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por = 1'b0;
        t_reset_state();
        t_first_expiry();
        t_second_expiry();
        t_rewrite();
        t_sysrst_keep();
        t_clear();
        t_mask();
        t_restart();
        t_unarmed();
        t_por_clear();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule